// File: doc/BRIEF.md
# Handshaked Variable-Latency Arithmetic Unit

This block is a 16-bit arithmetic unit that sits between a producer and a consumer. Each side uses its own valid/ready handshake. The producer presents two operands, a 2-bit operation code and a flag that complements operand A. The consumer collects one result word for each accepted request. The unit supports four operations: addition, the low half of a product, a logical right shift and a subtraction. Each operation has its own latency, and the subtraction takes a direct path that adds no execution cycles.

Only one request is in flight at a time, so results leave in the order the requests were accepted. The producer may raise the next request before the consumer has taken the previous result. That request waits at the input until the unit has returned to idle. A request whose valid stays high across transfers counts again on every acceptance. A controller with three states sequences the work:
- `ST_IDLE` asserts input ready. On `in_valid` it takes the request. It moves to `ST_HOLD` for a direct operation and to `ST_EXEC` for the others.
- `ST_EXEC` counts down the latency of the operation. When the count reaches 1 it loads the result and moves to `ST_HOLD`.
- `ST_HOLD` presents the result. It returns to `ST_IDLE` when `out_ready` is seen.

Top module: `hs_alu`

## Requirements
- R1: Operation code 0 returns (A' + B) mod 2^16, where A' is the effective operand A (see R5).
- R2: Operation code 1 returns the low 16 bits of A' * B.
- R3: Operation code 2 returns A' shifted right logically by B[3:0]. Bits 15:4 of B are ignored.
- R4: Operation code 3 returns (A' - B) mod 2^16. `out_valid` is high in the cycle right after the accepting edge.
- R5: When `in_inv_a` is 1, A' is the bitwise complement of `in_a`. When it is 0, A' is `in_a`. For example, A=5 and B=3 under addition with inversion gives 65533.
- R6: For operation codes 0, 1 and 2, `out_valid` rises ADD_LAT, MUL_LAT or SHR_LAT clock edges after the accepting edge. A latency parameter of 0 puts that operation on the direct path.
- R7: `in_ready` is low from the accepting edge until the result has been taken on the output.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: Results leave in acceptance order, one per accepted request. A valid held high with unchanged data across acceptances produces one result per acceptance.
- R10: A synchronous reset drives `out_valid` to 0 and `in_ready` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a request |
| in_ready | output | 1 | Unit can take a request |
| in_a | input | WIDTH | Operand A |
| in_b | input | WIDTH | Operand B |
| in_op | input | 2 | Operation: 0 add, 1 low multiply, 2 shift right, 3 subtract |
| in_inv_a | input | 1 | Complement A before the operation |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | WIDTH | Result word |

## Verification
The bench builds the unit with WIDTH=16, ADD_LAT=1, MUL_LAT=3 and SHR_LAT=2. Because the three timed latencies differ from each other and from the zero-cycle subtraction, a measured accept-to-valid distance identifies the path each operation took. A 3-cycle multiply also runs the countdown through its middle value. The consumer runs first with ready held high and then with a pseudo-random ready pattern. That pattern exercises the held-result window and requests that are presented while the previous result is still waiting.

// File: rtl/hs_alu_pkg.sv
package hs_alu_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_MULLO = 2'd1,
        OPC_SHR   = 2'd2,
        OPC_SUB   = 2'd3
    } opc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_HOLD = 2'd2
    } st_e;

    localparam int NUM_OPS = 4;

endpackage

// File: rtl/hs_alu_lat.sv
module hs_alu_lat
    import hs_alu_pkg::*;
#(
    parameter int ADD_LAT = 1,
    parameter int MUL_LAT = 2,
    parameter int SHR_LAT = 1,
    parameter int CNT_W   = 2
) (
    input  opc_e             op,
    output logic [CNT_W-1:0] cycles,
    output logic             direct
);
    localparam int LAT_TAB [NUM_OPS] = '{ADD_LAT, MUL_LAT, SHR_LAT, 0};

    logic [CNT_W-1:0] tab [NUM_OPS];
    logic [NUM_OPS-1:0] zero;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        if (LAT_TAB[i] == 0) begin : g_direct
            assign tab[i]  = '0;
            assign zero[i] = 1'b1;
        end else begin : g_timed
            assign tab[i]  = CNT_W'(LAT_TAB[i]);
            assign zero[i] = 1'b0;
        end
    end

    assign cycles = tab[op];
    assign direct = zero[op];

endmodule

// File: rtl/hs_alu_dp.sv
module hs_alu_dp
    import hs_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  opc_e             op,
    input  logic             inv_a,
    output logic [WIDTH-1:0] y
);
    localparam int SH_W = $clog2(WIDTH);

    logic [WIDTH-1:0] a_eff;
    logic [SH_W-1:0]  shamt;

    assign a_eff = inv_a ? ~a : a;
    assign shamt = b[SH_W-1:0];

    always_comb begin
        unique case (op)
            OPC_ADD:   y = a_eff + b;
            OPC_MULLO: y = a_eff * b;
            OPC_SHR:   y = a_eff >> shamt;
            OPC_SUB:   y = a_eff - b;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/hs_alu_ctrl.sv
module hs_alu_ctrl
    import hs_alu_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic             op_direct,
    input  logic [CNT_W-1:0] op_cycles,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load_ops,
    output logic             load_res
);
    st_e              st, st_nxt;
    logic [CNT_W-1:0] cnt;

    // state register and countdown
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE && in_valid) begin
                cnt <= op_cycles;
            end else if (st == ST_EXEC) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (in_valid) st_nxt = op_direct ? ST_HOLD : ST_EXEC;
            ST_EXEC: if (cnt == CNT_W'(1)) st_nxt = ST_HOLD;
            ST_HOLD: if (out_ready) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_ops  = 1'b0;
        load_res  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                in_ready = 1'b1;
                load_ops = in_valid;
                load_res = in_valid && op_direct;
            end
            ST_EXEC: load_res = (cnt == CNT_W'(1));
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end

    // R7: after an acceptance the input side stays closed for at least one cycle
    p_accept_closes_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R9: one result per request; a taken result is not offered again
    p_single_result_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid);

endmodule

// File: rtl/hs_alu.sv
module hs_alu
    import hs_alu_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int ADD_LAT = 1,
    parameter int MUL_LAT = 2,
    parameter int SHR_LAT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [1:0]       in_op,
    input  logic             in_inv_a,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);
    localparam int MAX_AM  = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int MAX_LAT = (MAX_AM > SHR_LAT) ? MAX_AM : SHR_LAT;
    localparam int CNT_W   = (MAX_LAT < 1) ? 1 : $clog2(MAX_LAT + 1);

    opc_e             op_live, op_q, op_sel;
    logic [WIDTH-1:0] a_q, b_q, a_sel, b_sel, y;
    logic             inv_q, inv_sel;
    logic [WIDTH-1:0] res_q;
    logic [CNT_W-1:0] op_cycles;
    logic             op_direct, load_ops, load_res;

    assign op_live = opc_e'(in_op);

    hs_alu_lat #(
        .ADD_LAT (ADD_LAT),
        .MUL_LAT (MUL_LAT),
        .SHR_LAT (SHR_LAT),
        .CNT_W   (CNT_W)
    ) u_lat (
        .op     (op_live),
        .cycles (op_cycles),
        .direct (op_direct)
    );

    hs_alu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .op_direct (op_direct),
        .op_cycles (op_cycles),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_ops  (load_ops),
        .load_res  (load_res)
    );

    // live inputs feed the datapath in the accepting cycle, captured ones later
    assign a_sel   = in_ready ? in_a     : a_q;
    assign b_sel   = in_ready ? in_b     : b_q;
    assign op_sel  = in_ready ? op_live  : op_q;
    assign inv_sel = in_ready ? in_inv_a : inv_q;

    hs_alu_dp #(.WIDTH(WIDTH)) u_dp (
        .a     (a_sel),
        .b     (b_sel),
        .op    (op_sel),
        .inv_a (inv_sel),
        .y     (y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            op_q  <= OPC_ADD;
            inv_q <= 1'b0;
            res_q <= '0;
        end else begin
            if (load_ops) begin
                a_q   <= in_a;
                b_q   <= in_b;
                op_q  <= op_live;
                inv_q <= in_inv_a;
            end
            if (load_res) begin
                res_q <= y;
            end
        end
    end

    assign out_data = res_q;

    // R7: input side is closed while a result waits
    p_closed_while_held_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R8: held result stays put until taken
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4: subtraction is visible right after its accepting edge
    p_direct_sub_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_op == 2'd3) |=> out_valid);

    // R6: a timed operation is not visible right after its accepting edge
    p_timed_delay_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !op_direct) |=> !out_valid);

    // R10: leaving reset, the unit is idle and empty
    p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (in_ready && !out_valid));

endmodule

// File: tb/hs_alu_test.sv
module hs_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int AL = 1;
    localparam int ML = 3;
    localparam int SL = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic [1:0]   in_op = '0;
    logic         in_inv_a = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit ready_rand = 1'b0;
    bit mon_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        logic [W-1:0] val;
        int           lat;
        int           acc;
        string        req;
    } exp_t;
    exp_t sb[$];

    hs_alu #(.WIDTH(W), .ADD_LAT(AL), .MUL_LAT(ML), .SHR_LAT(SL)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_op     (in_op),
        .in_inv_a  (in_inv_a),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [1:0] op, input logic inv);
        logic [W-1:0] ae;
        ae = inv ? ~a : a;
        case (op)
            2'd0:    return ae + b;
            2'd1:    return ae * b;
            2'd2:    return ae >> b[3:0];
            default: return ae - b;
        endcase
    endfunction

    // driver: presents a request, waits for acceptance, pushes the expectation
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [1:0] op, input logic inv);
        exp_t e;
        @(negedge clk);
        in_a = a; in_b = b; in_op = op; in_inv_a = inv; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        e.val = model(a, b, op, inv);
        e.lat = (op == 2'd3) ? 0 : (op == 2'd0) ? AL : (op == 2'd1) ? ML : SL;
        e.acc = cyc + 1;
        case (op)
            2'd0:    e.req = inv ? "R5 R1" : "R1";
            2'd1:    e.req = inv ? "R5 R2" : "R2";
            2'd2:    e.req = inv ? "R5 R3" : "R3";
            default: e.req = inv ? "R5 R4" : "R4";
        endcase
        sb.push_back(e);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_a = '0; in_b = '0; in_op = '0; in_inv_a = 1'b0;
    endtask

    // monitor: drives out_ready, pops and compares on each output transfer
    bit           seen_rise = 1'b0;
    bit           prev_hold = 1'b0;
    logic [W-1:0] prev_data = '0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_hold)
                check(out_valid && out_data == prev_data, "R8 held result", int'(out_data), int'(prev_data));
            if (out_valid)
                check(!in_ready, "R7 input closed while result held", int'(in_ready), 0);
            if (out_valid && !seen_rise && sb.size() > 0) begin
                check(cyc - sb[0].acc == sb[0].lat, (sb[0].lat == 0) ? "R4 zero latency" : "R6 latency",
                      cyc - sb[0].acc, sb[0].lat);
                seen_rise = 1'b1;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = ready_rand ? lfsr[0] : 1'b1;
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 unexpected result", int'(out_data), -1);
                end else begin
                    check(out_data == sb[0].val, {sb[0].req, " R9 ordered data"},
                          int'(out_data), int'(sb[0].val));
                    void'(sb.pop_front());
                end
                seen_rise = 1'b0;
            end
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=hang expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R10 in_ready in reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R10 idle after reset",
              int'({in_ready, out_valid}), 2);
        mon_on = 1'b1;

        // phase 1: consumer always ready; directed values
        send(16'd5, 16'd3, 2'd0, 1'b0);          // R1: 8
        idle_in(); idle_in();
        send(16'd2, 16'd3, 2'd1, 1'b0);          // R2: 6
        send(16'd5, 16'd3, 2'd0, 1'b1);          // R5: 65533
        idle_in();
        send(16'd5, 16'd3, 2'd3, 1'b0);          // R4: 2, zero latency
        idle_in(); idle_in();
        send(16'd13, 16'd2, 2'd2, 1'b0);         // R3: 3
        send(16'h8000, 16'd15, 2'd2, 1'b0);      // R3: 1
        send(16'hFFFF, 16'd20, 2'd2, 1'b0);      // R3: upper B bits ignored
        send(16'h1234, 16'h0100, 2'd1, 1'b0);    // R2: low half 0x3400
        send(16'hFFFF, 16'd1, 2'd0, 1'b0);       // R1: wrap to 0
        send(16'd3, 16'd5, 2'd3, 1'b0);          // R4: 0xFFFE
        send(16'd0, 16'd1, 2'd3, 1'b1);          // R5 R4: 0xFFFE
        // R9: valid held with unchanged data gives two transfers
        send(16'd5, 16'd3, 2'd0, 1'b0);
        send(16'd5, 16'd3, 2'd0, 1'b0);
        idle_in();
        repeat (10) @(negedge clk);

        // phase 2: consumer stalls pseudo-randomly
        ready_rand = 1'b1;
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] a, b;
            a = 16'(i * 16'h3A7 + 16'h51);
            b = 16'(i * 16'h1F3 + 16'h9);
            send(a, b, 2'(i % 4), 1'(i % 3 == 0));
            if (i % 5 == 0) idle_in();
        end
        idle_in();

        for (int k = 0; k < 2000 && sb.size() > 0; k++) @(negedge clk);
        check(sb.size() == 0, "R9 all results delivered", sb.size(), 0);
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule